// File: doc/BRIEF.md
# Conversion Timing Generator

This block turns a fast master clock into the slow timing a pair of sampled-data converters needs. It has two independent paths, one for transmit and one for receive. Each path has a first-stage counter that divides the master clock by a base value. A toggle stage turns that count into a square-wave filter clock whose period is twice the base value. A second-stage counter counts whole filter-clock periods and marks the end of each conversion period with a one-cycle tick. The nominal conversion period is therefore 2·A·B master-clock cycles.

Software can move a single conversion edge earlier or later by a whole number of master-clock cycles. It does this by posting a two-bit command. The command is held until the next conversion boundary. At that boundary the first-stage counter is loaded with the base value plus or minus a signed adjust value, for that one segment only. After that the path returns to the plain base value.

A synchronous mode drives the receive outputs from the transmit counters. In this mode the receive registers and receive commands have no effect on the outputs.

Top module: `conv_timing_gen`

## Requirements
- R1: While `rst` is high (a synchronous reset), both ticks are low and both filter clocks are high. Any posted command is discarded.
- R2: With a base value A of at least 1, the filter clock stays high for A master cycles after reset release, then goes low.
- R3: With no command posted, ticks are spaced 2·A·B master cycles apart. The first tick comes 2·A·B cycles after reset release.
- R4: A tick lasts exactly one master cycle. It coincides with a rising edge of the filter clock.
- R5: Command code 2'b01 adds the adjust value, read as two's complement. The conversion period after the next boundary becomes 2·A·B − A + (A + adjust) cycles, so a negative adjust shortens it.
- R6: Command code 2'b10 subtracts the adjust value. The affected period becomes 2·A·B − A + (A − adjust) cycles.
- R7: Codes 2'b00 and 2'b11 leave the period at 2·A·B. Any adjustment affects one conversion period only; the period after it is plain again.
- R8: A command is posted by a one-cycle `CmdValid` pulse. It does not change the conversion period in which it arrives. A later command posted before the boundary replaces the earlier one.
- R9: An adjusted base value below 1 is clamped to 1. A base value A or a count value B of zero is treated as 1.
- R10: With `syncMode` low, the receive path runs from its own registers and commands and is unaffected by transmit commands.
- R11: With `syncMode` high, the receive tick and filter clock equal the transmit ones on every cycle. Receive registers and receive commands are ignored.
- R12: With A = 9 and B = 36, ticks are 648 master cycles apart, which gives an 8 kHz rate from a 5.184 MHz master clock. With adjust = 1 and code 2'b01, the affected period is 649 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous reset, active high |
| syncMode | input | 1 | 1: receive outputs follow the transmit counters |
| txAReg | input | A_W | Transmit first-stage base value |
| txAdjReg | input | ADJ_W | Transmit signed adjust value |
| txBReg | input | B_W | Transmit filter periods per conversion |
| txCmd | input | 2 | Transmit adjust command code |
| txCmdValid | input | 1 | Posts `txCmd` |
| rxAReg | input | A_W | Receive first-stage base value |
| rxAdjReg | input | ADJ_W | Receive signed adjust value |
| rxBReg | input | B_W | Receive filter periods per conversion |
| rxCmd | input | 2 | Receive adjust command code |
| rxCmdValid | input | 1 | Posts `rxCmd` |
| txFclk | output | 1 | Transmit filter clock |
| txTick | output | 1 | Transmit conversion tick |
| rxFclk | output | 1 | Receive filter clock |
| rxTick | output | 1 | Receive conversion tick |

## Verification
The assertions check on every cycle that ticks are single-cycle pulses aligned to a rising filter-clock edge, and that in synchronous mode the receive outputs mirror the transmit outputs. Only the bench scenarios can show cycle counts between ticks: the plain 2·A·B spacing, the one-period shift under each command code, the clamping of small or zero values, the delayed and replaceable application of a posted command, and the independence of the receive path in asynchronous mode.

// File: rtl/tgen_pkg.sv
package tgen_pkg;

  typedef enum logic [1:0] {
    ADJ_KEEP     = 2'b00,
    ADJ_PLUS     = 2'b01,
    ADJ_MINUS    = 2'b10,
    ADJ_KEEP_ALT = 2'b11
  } adjCmd_e;

  // control -> datapath strobes
  typedef struct packed {
    logic    reloadA;  // first-stage counter reloads this cycle
    logic    useAdj;   // the reload starts a new conversion period
    logic    stepB;    // a filter period completed, not the last one
    logic    reloadB;  // conversion period completed
    adjCmd_e adjSel;   // command applied to an adjusted reload
  } tgenStrobe_t;

endpackage

// File: rtl/tgen_dp.sv
module tgen_dp
  import tgen_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int ADJ_W = 6,
  parameter int B_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [A_W-1:0]   aReg,
  input  logic [ADJ_W-1:0] adjReg,
  input  logic [B_W-1:0]   bReg,
  input  tgenStrobe_t      strobe,
  output logic             aDone,
  output logic             bDone
);
  localparam int SUM_W = ((A_W > ADJ_W) ? A_W : ADJ_W) + 2;
  localparam int CA_W  = SUM_W - 1;

  logic [CA_W-1:0]         cntA;
  logic [B_W-1:0]          cntB;
  logic [CA_W-1:0]         baseA;
  logic [CA_W-1:0]         adjA;
  logic [B_W-1:0]          baseB;
  logic signed [SUM_W-1:0] baseS;
  logic signed [SUM_W-1:0] adjS;
  logic signed [SUM_W-1:0] sumS;

  always_comb begin
    baseA = (aReg == '0) ? CA_W'(1) : CA_W'(aReg);
    baseB = (bReg == '0) ? B_W'(1) : bReg;
    baseS = signed'({1'b0, baseA});
    adjS  = signed'({{(SUM_W-ADJ_W){adjReg[ADJ_W-1]}}, adjReg});
    unique case (strobe.adjSel)
      ADJ_PLUS:  sumS = baseS + adjS;
      ADJ_MINUS: sumS = baseS - adjS;
      default:   sumS = baseS;
    endcase
    adjA = (sumS <= 0) ? CA_W'(1) : sumS[CA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cntA <= baseA;
      cntB <= baseB;
    end else begin
      if (strobe.reloadA) cntA <= strobe.useAdj ? adjA : baseA;
      else                cntA <= cntA - 1'b1;
      if (strobe.reloadB)    cntB <= baseB;
      else if (strobe.stepB) cntB <= cntB - 1'b1;
    end
  end

  assign aDone = (cntA == CA_W'(1));
  assign bDone = (cntB == B_W'(1));

endmodule

// File: rtl/tgen_ctrl.sv
module tgen_ctrl
  import tgen_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  cmd,
  input  logic        cmdValid,
  input  logic        aDone,
  input  logic        bDone,
  output tgenStrobe_t strobe,
  output logic        fclk,
  output logic        tick
);
  adjCmd_e cmdQ;
  logic    fclkQ;
  logic    tickQ;
  logic    periodEnd;
  logic    convEnd;

  // a filter period ends when the low half of it runs out
  assign periodEnd = aDone & ~fclkQ;
  assign convEnd   = periodEnd & bDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmdQ  <= ADJ_KEEP;
      fclkQ <= 1'b1;
      tickQ <= 1'b0;
    end else begin
      tickQ <= convEnd;
      if (aDone) fclkQ <= ~fclkQ;
      if (convEnd)       cmdQ <= cmdValid ? adjCmd_e'(cmd) : ADJ_KEEP;
      else if (cmdValid) cmdQ <= adjCmd_e'(cmd);
    end
  end

  always_comb begin
    strobe.reloadA = aDone;
    strobe.useAdj  = convEnd;
    strobe.stepB   = periodEnd & ~bDone;
    strobe.reloadB = convEnd;
    strobe.adjSel  = cmdQ;
  end

  assign fclk = fclkQ;
  assign tick = tickQ;

endmodule

// File: rtl/tgen_path.sv
module tgen_path
  import tgen_pkg::*;
#(
  parameter int A_W   = 5,
  parameter int ADJ_W = 6,
  parameter int B_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [A_W-1:0]   aReg,
  input  logic [ADJ_W-1:0] adjReg,
  input  logic [B_W-1:0]   bReg,
  input  logic [1:0]       cmd,
  input  logic             cmdValid,
  output logic             fclk,
  output logic             tick
);
  tgenStrobe_t strobe;
  logic        aDone;
  logic        bDone;

  tgen_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .cmd      (cmd),
    .cmdValid (cmdValid),
    .aDone    (aDone),
    .bDone    (bDone),
    .strobe   (strobe),
    .fclk     (fclk),
    .tick     (tick)
  );

  tgen_dp #(.A_W(A_W), .ADJ_W(ADJ_W), .B_W(B_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .aReg   (aReg),
    .adjReg (adjReg),
    .bReg   (bReg),
    .strobe (strobe),
    .aDone  (aDone),
    .bDone  (bDone)
  );

endmodule

// File: rtl/conv_timing_gen.sv
module conv_timing_gen #(
  parameter int A_W   = 5,
  parameter int ADJ_W = 6,
  parameter int B_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             syncMode,
  input  logic [A_W-1:0]   txAReg,
  input  logic [ADJ_W-1:0] txAdjReg,
  input  logic [B_W-1:0]   txBReg,
  input  logic [1:0]       txCmd,
  input  logic             txCmdValid,
  input  logic [A_W-1:0]   rxAReg,
  input  logic [ADJ_W-1:0] rxAdjReg,
  input  logic [B_W-1:0]   rxBReg,
  input  logic [1:0]       rxCmd,
  input  logic             rxCmdValid,
  output logic             txFclk,
  output logic             txTick,
  output logic             rxFclk,
  output logic             rxTick
);
  localparam int NPATH = 2;  // index 0 transmit, 1 receive

  logic [NPATH-1:0][A_W-1:0]   aRegs;
  logic [NPATH-1:0][ADJ_W-1:0] adjRegs;
  logic [NPATH-1:0][B_W-1:0]   bRegs;
  logic [NPATH-1:0][1:0]       cmds;
  logic [NPATH-1:0]            cmdValids;
  logic [NPATH-1:0]            fclkV;
  logic [NPATH-1:0]            tickV;

  assign aRegs     = {rxAReg, txAReg};
  assign adjRegs   = {rxAdjReg, txAdjReg};
  assign bRegs     = {rxBReg, txBReg};
  assign cmds      = {rxCmd, txCmd};
  assign cmdValids = {rxCmdValid, txCmdValid};

  for (genvar g = 0; g < NPATH; g++) begin : gPath
    tgen_path #(.A_W(A_W), .ADJ_W(ADJ_W), .B_W(B_W)) u_path (
      .clk      (clk),
      .rst      (rst),
      .aReg     (aRegs[g]),
      .adjReg   (adjRegs[g]),
      .bReg     (bRegs[g]),
      .cmd      (cmds[g]),
      .cmdValid (cmdValids[g]),
      .fclk     (fclkV[g]),
      .tick     (tickV[g])
    );
  end

  assign txFclk = fclkV[0];
  assign txTick = tickV[0];
  assign rxFclk = syncMode ? fclkV[0] : fclkV[1];
  assign rxTick = syncMode ? tickV[0] : tickV[1];

endmodule

// File: rtl/tgen_checker.sv
module tgen_checker (
  input logic clk,
  input logic rst,
  input logic syncMode,
  input logic txFclk,
  input logic txTick,
  input logic rxFclk,
  input logic rxTick
);
  // R4: ticks are single-cycle pulses
  p_tx_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
    txTick |=> !txTick);
  p_rx_tick_single_r4: assert property (@(posedge clk) disable iff (rst)
    rxTick |=> !rxTick);
  // R4: a tick comes with a rising filter-clock edge
  p_tx_tick_rise_r4: assert property (@(posedge clk) disable iff (rst)
    txTick |-> $rose(txFclk));
  p_rx_tick_rise_r4: assert property (@(posedge clk) disable iff (rst)
    rxTick |-> $rose(rxFclk));
  // R11: receive outputs mirror transmit ones in synchronous mode
  p_sync_follow_r11: assert property (@(posedge clk) disable iff (rst)
    syncMode |-> (rxTick == txTick) && (rxFclk == txFclk));
endmodule

bind conv_timing_gen tgen_checker u_tgen_checker (
  .clk      (clk),
  .rst      (rst),
  .syncMode (syncMode),
  .txFclk   (txFclk),
  .txTick   (txTick),
  .rxFclk   (rxFclk),
  .rxTick   (rxTick)
);

// File: tb/tb_conv_timing_gen.sv
`timescale 1ns/1ps
module tb_conv_timing_gen;
  localparam int A_W = 5, ADJ_W = 6, B_W = 6, NV = 8;

  // stimulus/expectation vectors: A, adjust, B, command code
  localparam int VA[NV] = '{3, 3, 3, 5, 3, 0, 9, 2};
  localparam int VJ[NV] = '{2, 2, -2, 3, 5, 1, 1, -8};
  localparam int VB[NV] = '{4, 4, 4, 2, 4, 2, 36, 3};
  localparam int VC[NV] = '{1, 2, 1, 3, 2, 1, 1, 2};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic             rst = 1'b1, syncMode = 1'b0;
  logic [A_W-1:0]   txAReg = '0, rxAReg = '0;
  logic [ADJ_W-1:0] txAdjReg = '0, rxAdjReg = '0;
  logic [B_W-1:0]   txBReg = '0, rxBReg = '0;
  logic [1:0]       txCmd = '0, rxCmd = '0;
  logic             txCmdValid = 1'b0, rxCmdValid = 1'b0;
  logic             txFclk, txTick, rxFclk, rxTick;

  conv_timing_gen #(.A_W(A_W), .ADJ_W(ADJ_W), .B_W(B_W)) dut (
    .clk(clk), .rst(rst), .syncMode(syncMode),
    .txAReg(txAReg), .txAdjReg(txAdjReg), .txBReg(txBReg),
    .txCmd(txCmd), .txCmdValid(txCmdValid),
    .rxAReg(rxAReg), .rxAdjReg(rxAdjReg), .rxBReg(rxBReg),
    .rxCmd(rxCmd), .rxCmdValid(rxCmdValid),
    .txFclk(txFclk), .txTick(txTick), .rxFclk(rxFclk), .rxTick(rxTick)
  );

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doReset();
    rst = 1'b1; txCmdValid = 1'b0; rxCmdValid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // cycles to next tick of path watchRx; optionally posts up to two commands
  task automatic gap(input bit watchRx, input bit drvRx,
                     input int at1, input logic [1:0] c1,
                     input int at2, input logic [1:0] c2, output int n);
    logic t;
    n = 0;
    do begin
      @(negedge clk);
      n++;
      if (n == at1 || n == at2) begin
        if (drvRx) begin rxCmd = (n == at1) ? c1 : c2; rxCmdValid = 1'b1; end
        else       begin txCmd = (n == at1) ? c1 : c2; txCmdValid = 1'b1; end
      end else begin
        txCmdValid = 1'b0; rxCmdValid = 1'b0;
      end
      t = watchRx ? rxTick : txTick;
    end while (!t && n < 6000);
    txCmdValid = 1'b0; rxCmdValid = 1'b0;
  endtask

  function automatic int maxOne(int v);
    return (v < 1) ? 1 : v;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL R3 watchdog actual 0 expected 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, a, adjA, plain, expAdj, mism;
    string tag;

    // R1: reset state
    txAReg = 3; txBReg = 4; rxAReg = 2; rxBReg = 5;
    repeat (2) @(negedge clk);
    check("R1 tick low in reset", int'(txTick) + int'(rxTick), 0);
    check("R1 fclk high in reset", int'(txFclk) + int'(rxFclk), 2);

    // vector table walk: R2 R3 R5 R6 R7 R8 R9 R12
    for (int i = 0; i < NV; i++) begin
      txAReg = A_W'(VA[i]); txAdjReg = ADJ_W'(VJ[i]); txBReg = B_W'(VB[i]);
      a = maxOne(VA[i]);
      plain = 2 * a * maxOne(VB[i]);
      adjA = (VC[i] == 1) ? a + VJ[i] : (VC[i] == 2) ? a - VJ[i] : a;
      adjA = maxOne(adjA);
      expAdj = plain - a + adjA;
      tag = (i == 4 || i == 5) ? "R9 clamp" : (i == 6) ? "R12 default" :
            (VC[i] == 1) ? "R5 plus" : (VC[i] == 2) ? "R6 minus" : "R7 keep";

      doReset();
      n = 0;
      while (txFclk && n < 200) begin @(negedge clk); n++; end
      check("R2 fclk high time", n, a);

      doReset();
      gap(1'b0, 1'b0, 0, 2'b00, 0, 2'b00, n);
      check("R3 first tick", n, plain);
      gap(1'b0, 1'b0, 2, 2'(VC[i]), 0, 2'b00, n);
      check("R8 arrival period unchanged", n, plain);
      gap(1'b0, 1'b0, 0, 2'b00, 0, 2'b00, n);
      check(tag, n, expAdj);
      gap(1'b0, 1'b0, 0, 2'b00, 0, 2'b00, n);
      check("R7 one period only", n, plain);
    end

    // R8: later command replaces earlier one
    txAReg = 3; txAdjReg = 2; txBReg = 4;
    doReset();
    gap(1'b0, 1'b0, 0, 2'b00, 0, 2'b00, n);
    gap(1'b0, 1'b0, 2, 2'b01, 4, 2'b00, n);
    gap(1'b0, 1'b0, 0, 2'b00, 0, 2'b00, n);
    check("R8 replaced command", n, 24);

    // R10: asynchronous, receive path independent
    syncMode = 1'b0; rxAReg = 2; rxAdjReg = 1; rxBReg = 5;
    doReset();
    gap(1'b1, 1'b0, 2, 2'b01, 0, 2'b00, n);
    check("R10 rx own period", n, 20);
    gap(1'b1, 1'b0, 0, 2'b00, 0, 2'b00, n);
    check("R10 rx ignores tx cmd", n, 20);
    gap(1'b1, 1'b1, 2, 2'b10, 0, 2'b00, n);
    gap(1'b1, 1'b0, 0, 2'b00, 0, 2'b00, n);
    check("R10 rx own cmd", n, 19);

    // R11: synchronous, receive follows transmit
    syncMode = 1'b1;
    doReset();
    gap(1'b1, 1'b0, 0, 2'b00, 0, 2'b00, n);
    check("R11 rx uses tx period", n, 24);
    gap(1'b1, 1'b1, 2, 2'b01, 0, 2'b00, n);
    gap(1'b1, 1'b0, 0, 2'b00, 0, 2'b00, n);
    check("R11 rx cmd ignored", n, 24);
    gap(1'b1, 1'b0, 2, 2'b01, 0, 2'b00, n);
    gap(1'b1, 1'b0, 0, 2'b00, 0, 2'b00, n);
    check("R11 rx follows tx cmd", n, 26);
    mism = 0;
    for (int k = 0; k < 200; k++) begin
      @(negedge clk);
      if (rxTick != txTick || rxFclk != txFclk) mism++;
    end
    check("R11 rx mirrors tx", mism, 0);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule